// File: doc/BRIEF.md
# Byte-Port Command/Response Handshake Controller

This block is the device end of a byte-wide host port with two addresses. Address 0 carries data. Address 1 returns a status byte on reads and takes a command byte on writes. The host opens a command by writing the start code and then pushes command bytes one at a time through the data address. Each byte is handed to a backend over a valid/ready stream. The host closes the command with the end code.

The block then pulls response bytes from the backend over a second valid/ready stream and returns them to the host one byte per data read. A head marker byte comes first and a tail marker byte comes last, and both are flagged in status. A cancel code written at any time drops whatever is in flight and returns the port to idle.

The response carries its own total length in big-endian form in bytes 2 to 5. The block uses that field to decide where the response ends, and it stops pulling from the backend at that point. Host signalling is a simple synchronous read/write strobe with a one-bit address.

Top module: `cmdresp_port_ctrl`

## Requirements
- R1: After reset, and in the cycle after a cancel command (0x22) written to address 1 in any phase, the status byte reads exactly 0x10. A cancel also clears the overrun and length-error flags and stops the backend response stream.
- R2: Reading address 1 returns the status byte {2'b00, IBR, RDY, A2, F0, IBF, OBF}, with OBF at bit 0, IBF at bit 1, F0 at bit 2, A2 at bit 3, RDY at bit 4 and IBR at bit 5. Reading address 0 returns the output byte register. A status read has no side effect.
- R3: The start command (0x01), written while idle, enters the write phase: RDY clears and IBR sets.
- R4: In the write phase, each write to address 0 while IBF is clear stores the byte, sets IBF and presents the byte on rx_data with rx_valid. IBF clears in the cycle after rx_valid and rx_ready are both high.
- R5: A data write while IBF is set is dropped, and the overrun output sets and stays set until reset or cancel.
- R6: The end command (0x03) in the write phase closes it. IBR clears, and later data writes produce no rx byte and no overrun.
- R7: In the cycle after the end command, OBF and F0 are set and the output byte is the head marker 0x01.
- R8: A host read of address 0 clears OBF, and F0 with it. A new output byte appears only after such a read. Payload bytes are presented with OBF set and F0 clear, in backend order.
- R9: For a response whose length field L (bytes 2..5, big-endian) is 6 or more, exactly L payload bytes are taken from the backend and passed to the host. tx_ready stays low afterwards.
- R10: If L is below 6, exactly 6 payload bytes are passed and resp_err sets.
- R11: After the last payload byte is read, the tail marker 0x03 appears with OBF and F0 set and RDY set. A data read while idle clears OBF and leaves RDY set.
- R12: A2 is 1 after a command write other than cancel, and 0 after a data write or a cancel.
- R13: Command codes that do not apply in the current phase are ignored: start outside idle, end outside the write phase, and any unknown code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | 0 = data, 1 = status/command |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational from address) |
| rx_valid | output | 1 | Command byte available to backend |
| rx_data | output | 8 | Command byte |
| rx_ready | input | 1 | Backend takes command byte |
| tx_valid | input | 1 | Backend response byte available |
| tx_data | input | 8 | Backend response byte |
| tx_ready | output | 1 | Block takes response byte |
| overrun | output | 1 | Sticky dropped-write flag |
| resp_err | output | 1 | Length field below minimum |

## Verification
A wrong phase shows in the status byte on the next cycle, because RDY and IBR come straight from the phase register. A miscounted or misparsed length field shows only at the end of a response. The tail marker then arrives early or late, or the backend is drained of bytes beyond the length, so every response length from 0 to 12 is swept and the count of bytes pulled from the backend is compared. A lost byte-handshake state shows as OBF either staying set after a read or a byte being replaced without one. For this reason OBF is checked after every single data read.

// File: rtl/cmdresp_pkg.sv
`timescale 1ns/1ps
package cmdresp_pkg;

    localparam logic [7:0] CMD_START  = 8'h01;
    localparam logic [7:0] CMD_END    = 8'h03;
    localparam logic [7:0] CMD_CANCEL = 8'h22;
    localparam logic [7:0] MARK_HEAD  = 8'h01;
    localparam logic [7:0] MARK_TAIL  = 8'h03;

    localparam int RESP_MIN  = 6;
    localparam int LEN_FIRST = 2;
    localparam int LEN_LAST  = 5;

    typedef enum logic [1:0] {PH_IDLE, PH_WRITE, PH_RESP} phase_e;

    typedef enum logic [2:0] {OS_IDLE, OS_HEAD, OS_BODY, OS_TAIL, OS_CLOSE} oseq_e;

    typedef struct packed {
        logic cancel;
        logic start;
        logic fin;
        logic cmd_wr;
        logic data_wr;
        logic data_rd;
    } hostop_t;

    typedef struct packed {
        logic ibr;
        logic rdy;
        logic a2;
        logic f0;
        logic ibf;
        logic obf;
    } status_t;

    function automatic logic [7:0] pack_status(input status_t s);
        return {2'b00, s};
    endfunction

endpackage

// File: rtl/cmdresp_decode.sv
`timescale 1ns/1ps
module cmdresp_decode
    import cmdresp_pkg::*;
(
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_addr,
    input  logic [7:0] host_wdata,
    output hostop_t    op
);

    always_comb begin
        op.cmd_wr  = host_wr && host_addr;
        op.data_wr = host_wr && !host_addr;
        op.data_rd = host_rd && !host_addr;
        op.cancel  = op.cmd_wr && (host_wdata == CMD_CANCEL);
        op.start   = op.cmd_wr && (host_wdata == CMD_START);
        op.fin     = op.cmd_wr && (host_wdata == CMD_END);
    end

endmodule

// File: rtl/cmdresp_inbuf.sv
`timescale 1ns/1ps
module cmdresp_inbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cancel,
    input  logic          accept_en,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    input  logic          rx_ready,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          overrun
);

    logic          full_q;
    logic [DW-1:0] byte_q;
    logic          ovr_q;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (full_q && rx_ready)
                full_q <= 1'b0;
            if (data_wr && accept_en) begin
                if (full_q) begin
                    ovr_q <= 1'b1;
                end else begin
                    full_q <= 1'b1;
                    byte_q <= wdata;
                end
            end
        end
    end

    assign rx_valid = full_q;
    assign rx_data  = byte_q;
    assign overrun  = ovr_q;

    // R4: handshake empties the input register on the next cycle
    a_r4_ibf_clears: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready) |=> !rx_valid);

    // R5: overrun stays until cancel
    a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !cancel) |=> overrun);

endmodule

// File: rtl/cmdresp_outseq.sv
`timescale 1ns/1ps
module cmdresp_outseq
    import cmdresp_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CNT_W = 16,
    parameter int LEN_W = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cancel,
    input  logic          start,
    input  logic          data_rd,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic          tx_ready,
    output logic          obf,
    output logic          f0,
    output logic [DW-1:0] obyte,
    output logic          done,
    output logic          resp_err
);

    oseq_e            state;
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] len;
    logic             err_q;

    logic [CNT_W-1:0] cnt_nx;
    logic [LEN_W-1:0] len_nx;
    logic             in_len;
    logic             short_len;
    logic             last;

    always_comb begin
        cnt_nx    = cnt + 1'b1;
        in_len    = (cnt >= CNT_W'(LEN_FIRST)) && (cnt <= CNT_W'(LEN_LAST));
        len_nx    = in_len ? {len[LEN_W-DW-1:0], tx_data} : len;
        short_len = (cnt_nx == CNT_W'(RESP_MIN)) && (len_nx < LEN_W'(RESP_MIN));
        last      = short_len ||
                    ((cnt_nx >= CNT_W'(RESP_MIN)) && (len_nx == LEN_W'(cnt_nx)));
    end

    assign tx_ready = (state == OS_BODY) && !obf;
    assign done     = (state == OS_CLOSE);
    assign resp_err = err_q;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            state <= OS_IDLE;
            obf   <= 1'b0;
            f0    <= 1'b0;
            obyte <= '0;
            cnt   <= '0;
            len   <= '0;
            err_q <= 1'b0;
        end else begin
            case (state)
                OS_IDLE: begin
                    if (start) begin
                        obyte <= MARK_HEAD;
                        obf   <= 1'b1;
                        f0    <= 1'b1;
                        cnt   <= '0;
                        len   <= '0;
                        err_q <= 1'b0;
                        state <= OS_HEAD;
                    end else if (data_rd) begin
                        obf <= 1'b0;
                        f0  <= 1'b0;
                    end
                end
                OS_HEAD: begin
                    if (data_rd) begin
                        obf   <= 1'b0;
                        f0    <= 1'b0;
                        state <= OS_BODY;
                    end
                end
                OS_BODY: begin
                    if (tx_valid && tx_ready) begin
                        obyte <= tx_data;
                        obf   <= 1'b1;
                        f0    <= 1'b0;
                        cnt   <= cnt_nx;
                        len   <= len_nx;
                        if (short_len)
                            err_q <= 1'b1;
                        if (last)
                            state <= OS_TAIL;
                    end else if (data_rd) begin
                        obf <= 1'b0;
                    end
                end
                OS_TAIL: begin
                    if (data_rd) begin
                        obf   <= 1'b0;
                        state <= OS_CLOSE;
                    end
                end
                OS_CLOSE: begin
                    obyte <= MARK_TAIL;
                    obf   <= 1'b1;
                    f0    <= 1'b1;
                    state <= OS_IDLE;
                end
                default: state <= OS_IDLE;
            endcase
        end
    end

    // R7: head marker follows the end command
    a_r7_head_marker: assert property (@(posedge clk) disable iff (rst)
        start |=> (obf && f0 && obyte == MARK_HEAD));

    // R8: a data read empties the output register
    a_r8_read_clears_obf: assert property (@(posedge clk) disable iff (rst)
        (data_rd && obf && !cancel && !start) |=> !obf);

    // R8: an unread byte is never replaced
    a_r8_hold_byte: assert property (@(posedge clk) disable iff (rst)
        (obf && !data_rd && !cancel && !start) |=> (obf && $stable(obyte)));

    // R9: no backend pull once the tail is queued
    a_r9_no_pull_after_last: assert property (@(posedge clk) disable iff (rst)
        (state == OS_TAIL) |-> !tx_ready);

endmodule

// File: rtl/cmdresp_port_ctrl.sv
`timescale 1ns/1ps
module cmdresp_port_ctrl
    import cmdresp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LEN_W = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    input  logic       rx_ready,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       overrun,
    output logic       resp_err
);

    localparam int DW = 8;

    hostop_t    op;
    phase_e     phase;
    logic       a2_q;
    logic       obf;
    logic       f0;
    logic [7:0] obyte;
    logic       seq_done;
    logic       resp_go;
    status_t    st;
    logic [7:0] status_byte;

    cmdresp_decode u_decode (
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .op         (op)
    );

    cmdresp_inbuf #(.DW(DW)) u_inbuf (
        .clk       (clk),
        .rst       (rst),
        .cancel    (op.cancel),
        .accept_en (phase == PH_WRITE),
        .data_wr   (op.data_wr),
        .wdata     (host_wdata),
        .rx_ready  (rx_ready),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .overrun   (overrun)
    );

    assign resp_go = (phase == PH_WRITE) && op.fin;

    cmdresp_outseq #(.DW(DW), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_outseq (
        .clk      (clk),
        .rst      (rst),
        .cancel   (op.cancel),
        .start    (resp_go),
        .data_rd  (op.data_rd),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .obf      (obf),
        .f0       (f0),
        .obyte    (obyte),
        .done     (seq_done),
        .resp_err (resp_err)
    );

    always_ff @(posedge clk) begin
        if (rst || op.cancel) begin
            phase <= PH_IDLE;
            a2_q  <= 1'b0;
        end else begin
            if (op.cmd_wr)
                a2_q <= 1'b1;
            else if (op.data_wr)
                a2_q <= 1'b0;
            case (phase)
                PH_IDLE:  if (op.start)  phase <= PH_WRITE;
                PH_WRITE: if (op.fin)    phase <= PH_RESP;
                PH_RESP:  if (seq_done)  phase <= PH_IDLE;
                default:                 phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        st = '{ibr: (phase == PH_WRITE), rdy: (phase == PH_IDLE),
               a2: a2_q, f0: f0, ibf: rx_valid, obf: obf};
        status_byte = pack_status(st);
        host_rdata  = host_addr ? status_byte : obyte;
    end

    // R1: cancel leaves only the ready flag
    a_r1_cancel_status: assert property (@(posedge clk) disable iff (rst)
        op.cancel |=> (status_byte == 8'h10));

    // R6: no byte enters the input register outside the write phase
    a_r6_no_accept: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_WRITE && !rx_valid) |=> !rx_valid);

    // R11: draining a stale byte while idle keeps the port ready
    a_r11_drain_ready: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && op.data_rd && !op.start && !op.cancel)
            |=> (phase == PH_IDLE && !obf));

endmodule

// File: tb/test_cmdresp_port_ctrl.sv
`timescale 1ns/1ps
module test_cmdresp_port_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr, host_rd, host_addr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       rx_valid, rx_ready;
    logic [7:0] rx_data;
    logic       tx_valid, tx_ready;
    logic [7:0] tx_data;
    logic       overrun, resp_err;

    int n_vec = 0;
    int n_bad = 0;

    logic       tx_on, tx_clr, rx_clr;
    int         tx_idx, tx_count, tx_len;
    int         rx_n;
    logic [7:0] rx_got [0:31];

    always #2.5 clk = ~clk;

    cmdresp_port_ctrl i_cmdresp_port_ctrl (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .overrun(overrun), .resp_err(resp_err)
    );

    function automatic logic [7:0] resp_byte(input int len, input int i);
        if (i >= 2 && i <= 5)
            return 8'((len >> (8 * (5 - i))) & 255);
        return 8'((i * 37 + len * 11 + 5) & 255);
    endfunction

    function automatic logic [7:0] cmd_byte(input int n, input int i);
        return 8'((i * 19 + n * 3 + 1) & 255);
    endfunction

    assign tx_valid = tx_on && (tx_idx < tx_count);
    assign tx_data  = resp_byte(tx_len, tx_idx);

    always @(posedge clk) begin
        if (tx_clr) tx_idx <= 0;
        else if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
        if (rx_clr) rx_n <= 0;
        else if (rx_valid && rx_ready) begin
            if (rx_n < 32) rx_got[rx_n] <= rx_data;
            rx_n <= rx_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(output logic [7:0] d);
        host_addr = 1'b0; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic peek(output logic [7:0] s);
        host_addr = 1'b1;
        #1 s = host_rdata;
    endtask

    task automatic wait_stat(input logic [7:0] mask, input logic [7:0] val,
                             input string req, output logic [7:0] s);
        for (int k = 0; k < 200; k++) begin
            peek(s);
            if ((s & mask) == val) return;
            @(negedge clk);
        end
        chk(req, int'(s & mask), int'(val));
    endtask

    task automatic clear_models(input int len, input int cnt);
        tx_len = len; tx_count = cnt; tx_clr = 1'b1; rx_clr = 1'b1;
        @(negedge clk);
        tx_clr = 1'b0; rx_clr = 1'b0;
    endtask

    task automatic do_txn(input int ncmd, input int len);
        logic [7:0] s, d;
        int exp_n, k;
        exp_n = (len < 6) ? 6 : len;
        hwrite(1'b1, 8'h22);
        peek(s); chk("R1 cancel status", s, 8'h10);
        clear_models(len, exp_n + 3);
        rx_ready = 1'b1; tx_on = 1'b1;
        hwrite(1'b1, 8'h01);
        peek(s); chk("R3 start status", s, 8'h28);
        for (int i = 0; i < ncmd; i++) begin
            wait_stat(8'h02, 8'h00, "R4 ibf drain", s);
            hwrite(1'b0, cmd_byte(ncmd, i));
        end
        wait_stat(8'h02, 8'h00, "R4 ibf drain", s);
        chk("R4 rx count", rx_n, ncmd);
        for (int i = 0; i < ncmd; i++) chk("R4 rx byte", rx_got[i], cmd_byte(ncmd, i));
        hwrite(1'b1, 8'h03);
        hwrite(1'b0, 8'hEE);
        peek(s); chk("R7 head status", s, 8'h05);
        repeat (2) @(negedge clk);
        chk("R6 late write ignored", rx_n, ncmd);
        chk("R6 no overrun", overrun, 0);
        hread(d); chk("R7 head byte", d, 8'h01);
        k = 0;
        while (k < 64) begin
            wait_stat(8'h01, 8'h01, "R8 obf", s);
            if (s[2]) break;
            chk("R8 payload status", s, 8'h01);
            hread(d); chk("R8 payload byte", d, resp_byte(len, k));
            peek(s); chk("R8 obf cleared", s[0], 0);
            k++;
        end
        chk("R11 tail status", s, 8'h15);
        chk("R9 payload count", k, exp_n);
        chk("R9 backend pulls", tx_idx, exp_n);
        chk("R10 length error", resp_err, (len < 6) ? 1 : 0);
        hread(d); chk("R11 tail byte", d, 8'h03);
        peek(s); chk("R11 ready after tail", s, 8'h10);
        hread(d);
        peek(s); chk("R11 drain read", s, 8'h10);
        chk("R9 no extra pull", tx_idx, exp_n);
        tx_on = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] s, d;
        int hold;
        rst = 1'b1; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
        rx_ready = 0; tx_on = 0; tx_clr = 1; rx_clr = 1; tx_len = 0; tx_count = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0; tx_clr = 0; rx_clr = 0;

        peek(s); chk("R1 reset status", s, 8'h10);
        chk("R1 reset overrun", overrun, 0);
        chk("R1 reset err", resp_err, 0);
        chk("R2 reset tx_ready", tx_ready, 0);

        // R13: end and unknown codes ignored while idle; R12: A2 tracks writes
        hwrite(1'b1, 8'h03);
        peek(s); chk("R13 end ignored idle / R12 a2", s, 8'h18);
        hwrite(1'b1, 8'h7F);
        peek(s); chk("R13 unknown code", s, 8'h18);
        hwrite(1'b0, 8'h55);
        peek(s); chk("R12 a2 cleared by data", s, 8'h10);
        repeat (2) @(negedge clk);
        chk("R6 idle data ignored", rx_n, 0);

        // sweep response lengths, including the invalid short ones (R10)
        for (int len = 0; len <= 12; len++) do_txn((len * 3) % 7, len);

        // R5 overrun and R4 IBF timing
        hwrite(1'b1, 8'h22);
        clear_models(0, 0);
        rx_ready = 1'b0;
        hwrite(1'b1, 8'h01);
        hwrite(1'b0, 8'hA5);
        peek(s); chk("R4 ibf set", s, 8'h22);
        hwrite(1'b0, 8'h5A);
        chk("R5 overrun set", overrun, 1);
        rx_ready = 1'b1;
        @(negedge clk);
        peek(s); chk("R4 ibf clears after handshake", s, 8'h20);
        chk("R5 dropped byte", rx_n, 1);
        chk("R4 kept byte", rx_got[0], 8'hA5);
        repeat (3) @(negedge clk);
        chk("R5 overrun sticky", overrun, 1);
        hwrite(1'b1, 8'h22);
        chk("R1 cancel clears overrun", overrun, 0);
        peek(s); chk("R1 status after cancel", s, 8'h10);

        // R1 cancel mid-response, R13 start ignored in response
        clear_models(10, 13);
        tx_on = 1'b1;
        hwrite(1'b1, 8'h01);
        hwrite(1'b1, 8'h03);
        hread(d); chk("R7 head byte", d, 8'h01);
        hwrite(1'b1, 8'h01);
        wait_stat(8'h01, 8'h01, "R8 obf", s);
        chk("R13 start ignored in response", s, 8'h09);
        hread(d); chk("R8 first payload", d, resp_byte(10, 0));
        hwrite(1'b1, 8'h22);
        peek(s); chk("R1 cancel mid-response", s, 8'h10);
        hold = tx_idx;
        repeat (4) @(negedge clk);
        chk("R1 backend stopped", tx_idx, hold);
        chk("R1 tx_ready low", tx_ready, 0);
        peek(s); chk("R1 still idle", s, 8'h10);
        tx_on = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule